// File: doc/BRIEF.md
# Dual-Converter Mode and Control Sequencer

This block is the register-side controller for a device that contains a main converter and an auxiliary converter. A host writes configuration through a small write/read register port. The block turns those writes into reset pulses for each converter, keeps the output cadence of both converters, and runs calibration requests. The analog front end, the digital filter and the calibration arithmetic are not part of this block. Conversion results appear as single-cycle pulses, and calibration coefficient stores appear as a write strobe with a pair selector.

Resets are not symmetric. A write to the mode field, or any write that touches an enabled main converter, restarts both converters. A write to the auxiliary control register restarts only the auxiliary side. The main output cadence then runs on without a break, and the auxiliary side waits for the main output events and locks to them. A calibration mode runs for a fixed number of cycles with the filter rate forced to its maximum. It then stores its coefficients and returns the mode field to idle without any further host action.

Register map (3-bit address):

- 0: mode. Bits 2:0 hold the mode field: 001 idle, 010 continuous, 100/101 main zero/full-scale calibration, 110/111 auxiliary zero/full-scale calibration.
- 1: status (read-only). Bit 0 main ready, bit 1 aux ready, bit 2 main calibration done, bit 3 aux calibration done, bit 4 calibration busy.
- 2: main control. Bit 7 is the enable and goes first on a serial stream. Bit 6 word length, bits 5:4 channel, bit 3 polarity, bits 2:0 range.
- 3: aux control. Bit 7 is the enable; bits 6:4 select the channel, and 111 selects the temperature sensor.
- 4: filter rate.

Top module: `dualconv_seq`

## Requirements
- R1: After reset the mode register reads 0x01, status reads 0x00, main control reads 0x07, aux control reads 0x00, the filter rate reads RATE_RST (default 5), and every pulse output is low.
- R2: Every write to address 0 makes main_rst_o and aux_rst_o high for exactly the one cycle after the write edge, even when the written mode equals the stored one.
- R3: A write to address 2 raises both reset outputs when bit 7 of either the old or the new value is 1. When both are 0, neither reset output rises.
- R4: A write to address 3 raises aux_rst_o alone. The main_result_o cadence continues with no shift.
- R5: With main bit 7 set and mode 010, main_result_o pulses R cycles after the last main reset and then every R+1 cycles, where R is the filter rate.
- R6: After an aux reset with aux bit 7 set, aux_result_o stays low through the first two main_result_o pulses. It pulses together with the third pulse and with every later one, and it is never high without main_result_o.
- R7: Status bit 0 is set by a main result and bit 1 by an aux result. Each bit is cleared by the reset of its own converter.
- R8: A write of a calibration mode clears status bits 0 to 3 and sets bit 4 at the write edge. While bit 4 is set, rate_eff_o is all ones and address 4 still reads the user value.
- R9: CAL_CYCLES cycles after the calibration write edge, cal_wr_o pulses for one cycle with cal_pair_o equal to mode bits 1:0. At that point the mode reads 001, status bit 2 (main) or bit 3 (aux) is set, bit 4 is clear, and rate_eff_o returns to the last written rate, including a rate written during calibration.
- R10: An aux calibration (110 or 111) written while aux bits 6:4 are 111 never completes. cal_wr_o stays low, the mode keeps the written value and status bit 4 stays clear.
- R11: A mode write on the same edge at which calibration would finish takes precedence. No cal_wr_o pulse follows, and the mode takes the written value.
- R12: Writes to status change nothing and raise no reset. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| main_rst_o | output | 1 | Main converter reset pulse |
| aux_rst_o | output | 1 | Aux converter reset pulse |
| main_result_o | output | 1 | Main conversion result pulse |
| aux_result_o | output | 1 | Aux conversion result pulse |
| cal_wr_o | output | 1 | Calibration coefficient store strobe |
| cal_pair_o | output | 2 | Calibration register pair selector |
| rate_eff_o | output | 8 | Filter rate in effect |

## Verification
Two pairs of events can land in the same cycle. The first is a host mode write and the natural end of a calibration. The bench times the write so that its edge is the one on which the calibration counter expires, and it expects the write to win: no store strobe, the written mode retained, and busy cleared. The second is an aux reset and a main result pulse. The bench counts main pulses from the aux write onward. It checks that the aux pulse appears on the third one and that the main cadence keeps its phase across the write.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  localparam int REG_W  = 8;
  localparam int EN_BIT = 7;

  typedef enum logic [2:0] {
    A_MODE = 3'd0,
    A_STAT = 3'd1,
    A_MAIN = 3'd2,
    A_AUX  = 3'd3,
    A_RATE = 3'd4
  } addr_e;

  localparam logic [2:0] M_IDLE = 3'b001;
  localparam logic [2:0] M_CONV = 3'b010;

  typedef struct packed {
    logic busy;
    logic aux_ok;
    logic main_ok;
    logic rdy_aux;
    logic rdy_main;
  } stat_t;

endpackage

// File: rtl/dcs_regs.sv
module dcs_regs
  import dcs_pkg::*;
#(
  parameter int                RATE_W   = 8,
  parameter logic [RATE_W-1:0] RATE_RST = 5,
  parameter logic [REG_W-1:0]  MAIN_RST = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              force_idle,
  input  stat_t             stat,
  output logic [REG_W-1:0]  rdata,
  output logic [2:0]        mode_o,
  output logic              main_en_o,
  output logic              aux_en_o,
  output logic [2:0]        aux_sel_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              mode_wr_o,
  output logic              main_rst_req_o,
  output logic              aux_rst_req_o
);

  logic [2:0]        mode_q, mode_d;
  logic [REG_W-1:0]  main_q, main_d;
  logic [REG_W-1:0]  aux_q, aux_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic              wr_mode, wr_main, wr_aux, wr_rate;

  // write decode and reset priority
  always_comb begin
    wr_mode = we && (addr == A_MODE);
    wr_main = we && (addr == A_MAIN);
    wr_aux  = we && (addr == A_AUX);
    wr_rate = we && (addr == A_RATE);
    main_rst_req_o = wr_mode || (wr_main && (main_q[EN_BIT] || wdata[EN_BIT]));
    aux_rst_req_o  = main_rst_req_o || wr_aux;
    mode_wr_o      = wr_mode;
  end

  // next state
  always_comb begin
    mode_d = mode_q;
    if (wr_mode)         mode_d = wdata[2:0];
    else if (force_idle) mode_d = M_IDLE;
    main_d = wr_main ? wdata : main_q;
    aux_d  = wr_aux  ? wdata : aux_q;
    rate_d = wr_rate ? wdata[RATE_W-1:0] : rate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_IDLE;
      main_q <= MAIN_RST;
      aux_q  <= '0;
      rate_q <= RATE_RST;
    end else begin
      mode_q <= mode_d;
      main_q <= main_d;
      aux_q  <= aux_d;
      rate_q <= rate_d;
    end
  end

  // read mux
  always_comb begin
    case (addr)
      A_MODE:  rdata = {{(REG_W-3){1'b0}}, mode_q};
      A_STAT:  rdata = {{(REG_W-$bits(stat_t)){1'b0}}, stat};
      A_MAIN:  rdata = main_q;
      A_AUX:   rdata = aux_q;
      A_RATE:  rdata = REG_W'(rate_q);
      default: rdata = '0;
    endcase
  end

  assign mode_o    = mode_q;
  assign main_en_o = main_q[EN_BIT];
  assign aux_en_o  = aux_q[EN_BIT];
  assign aux_sel_o = aux_q[6:4];
  assign rate_o    = rate_q;

endmodule

// File: rtl/dcs_cadence.sv
module dcs_cadence #(
  parameter int RATE_W       = 8,
  parameter int ALIGN_EVENTS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              main_rst_req,
  input  logic              aux_rst_req,
  input  logic              main_run,
  input  logic              aux_en,
  input  logic [RATE_W-1:0] rate_eff,
  output logic              main_evt,
  output logic              aux_evt,
  output logic              rdy_main,
  output logic              rdy_aux
);

  localparam int AW = (ALIGN_EVENTS > 1) ? $clog2(ALIGN_EVENTS) : 1;
  localparam logic [AW-1:0] ALIGN_LAST = AW'(ALIGN_EVENTS - 1);

  logic [RATE_W-1:0] cnt_q, cnt_d;
  logic [AW-1:0]     align_q, align_d;
  logic              rdy_main_q, rdy_main_d;
  logic              rdy_aux_q, rdy_aux_d;
  logic              aux_run, aligned;

  always_comb begin
    main_evt = main_run && (cnt_q >= rate_eff);
    aux_run  = aux_en && main_run;
    aligned  = (align_q == ALIGN_LAST);
    aux_evt  = aux_run && main_evt && aligned;
  end

  always_comb begin
    if (main_rst_req || !main_run || main_evt) cnt_d = '0;
    else                                       cnt_d = cnt_q + 1'b1;

    align_d = align_q;
    if (aux_rst_req)                            align_d = '0;
    else if (aux_run && main_evt && !aligned)   align_d = align_q + 1'b1;

    rdy_main_d = rdy_main_q;
    if (main_rst_req)  rdy_main_d = 1'b0;
    else if (main_evt) rdy_main_d = 1'b1;

    rdy_aux_d = rdy_aux_q;
    if (aux_rst_req)  rdy_aux_d = 1'b0;
    else if (aux_evt) rdy_aux_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      align_q    <= '0;
      rdy_main_q <= 1'b0;
      rdy_aux_q  <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      align_q    <= align_d;
      rdy_main_q <= rdy_main_d;
      rdy_aux_q  <= rdy_aux_d;
    end
  end

  assign rdy_main = rdy_main_q;
  assign rdy_aux  = rdy_aux_q;

endmodule

// File: rtl/dcs_cal.sv
module dcs_cal #(
  parameter int         CAL_CYCLES = 16,
  parameter logic [2:0] TEMP_SEL   = 3'b111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [2:0] wmode,
  input  logic [2:0] aux_sel,
  output logic       busy_o,
  output logic       done_o,
  output logic       cal_wr_o,
  output logic [1:0] pair_o,
  output logic       main_ok_o,
  output logic       aux_ok_o
);

  localparam int CW = (CAL_CYCLES > 1) ? $clog2(CAL_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CAL_CYCLES - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    kind_q, kind_d;
  logic          main_ok_q, main_ok_d;
  logic          aux_ok_q, aux_ok_d;
  logic          wr_q;
  logic          req_cal, blocked, done;

  always_comb begin
    req_cal = mode_wr && wmode[2];
    blocked = wmode[1] && (aux_sel == TEMP_SEL);
    done    = busy_q && (cnt_q == LAST) && !mode_wr;
  end

  always_comb begin
    busy_d    = busy_q;
    cnt_d     = cnt_q;
    kind_d    = kind_q;
    main_ok_d = main_ok_q;
    aux_ok_d  = aux_ok_q;
    if (mode_wr) begin
      busy_d = req_cal && !blocked;
      cnt_d  = '0;
      if (req_cal) begin
        kind_d    = wmode[1:0];
        main_ok_d = 1'b0;
        aux_ok_d  = 1'b0;
      end
    end else if (done) begin
      busy_d = 1'b0;
      if (kind_q[1]) aux_ok_d  = 1'b1;
      else           main_ok_d = 1'b1;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      kind_q    <= '0;
      main_ok_q <= 1'b0;
      aux_ok_q  <= 1'b0;
      wr_q      <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      cnt_q     <= cnt_d;
      kind_q    <= kind_d;
      main_ok_q <= main_ok_d;
      aux_ok_q  <= aux_ok_d;
      wr_q      <= done;
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done;
  assign cal_wr_o  = wr_q;
  assign pair_o    = kind_q;
  assign main_ok_o = main_ok_q;
  assign aux_ok_o  = aux_ok_q;

endmodule

// File: rtl/dualconv_seq.sv
module dualconv_seq
  import dcs_pkg::*;
#(
  parameter int                CAL_CYCLES   = 16,
  parameter int                RATE_W       = 8,
  parameter logic [RATE_W-1:0] RATE_RST     = 5,
  parameter logic [REG_W-1:0]  MAIN_RST     = 8'h07,
  parameter logic [2:0]        TEMP_SEL     = 3'b111,
  parameter int                ALIGN_EVENTS = 3,
  parameter int                SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              main_rst_o,
  output logic              aux_rst_o,
  output logic              main_result_o,
  output logic              aux_result_o,
  output logic              cal_wr_o,
  output logic [1:0]        cal_pair_o,
  output logic [RATE_W-1:0] rate_eff_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign srst_n = sync_q[SYNC_STAGES-1];

  logic [2:0]        mode_q;
  logic              main_en, aux_en, mode_wr;
  logic [2:0]        aux_sel;
  logic [RATE_W-1:0] rate_q;
  logic              main_rst_req, aux_rst_req;
  logic              cal_busy, cal_done, main_ok, aux_ok;
  logic              rdy_main, rdy_aux, main_run;
  logic              main_rst_q, aux_rst_q;
  stat_t             stat;

  always_comb begin
    stat.busy     = cal_busy;
    stat.aux_ok   = aux_ok;
    stat.main_ok  = main_ok;
    stat.rdy_aux  = rdy_aux;
    stat.rdy_main = rdy_main;
    main_run      = main_en && (mode_q == M_CONV);
    rate_eff_o    = cal_busy ? '1 : rate_q;
  end

  dcs_regs #(
    .RATE_W  (RATE_W),
    .RATE_RST(RATE_RST),
    .MAIN_RST(MAIN_RST)
  ) u_regs (
    .clk           (clk),
    .rst_n         (srst_n),
    .we            (reg_we),
    .addr          (reg_addr),
    .wdata         (reg_wdata),
    .force_idle    (cal_done),
    .stat          (stat),
    .rdata         (reg_rdata),
    .mode_o        (mode_q),
    .main_en_o     (main_en),
    .aux_en_o      (aux_en),
    .aux_sel_o     (aux_sel),
    .rate_o        (rate_q),
    .mode_wr_o     (mode_wr),
    .main_rst_req_o(main_rst_req),
    .aux_rst_req_o (aux_rst_req)
  );

  dcs_cadence #(
    .RATE_W      (RATE_W),
    .ALIGN_EVENTS(ALIGN_EVENTS)
  ) u_cad (
    .clk         (clk),
    .rst_n       (srst_n),
    .main_rst_req(main_rst_req),
    .aux_rst_req (aux_rst_req),
    .main_run    (main_run),
    .aux_en      (aux_en),
    .rate_eff    (rate_eff_o),
    .main_evt    (main_result_o),
    .aux_evt     (aux_result_o),
    .rdy_main    (rdy_main),
    .rdy_aux     (rdy_aux)
  );

  dcs_cal #(
    .CAL_CYCLES(CAL_CYCLES),
    .TEMP_SEL  (TEMP_SEL)
  ) u_cal (
    .clk      (clk),
    .rst_n    (srst_n),
    .mode_wr  (mode_wr),
    .wmode    (reg_wdata[2:0]),
    .aux_sel  (aux_sel),
    .busy_o   (cal_busy),
    .done_o   (cal_done),
    .cal_wr_o (cal_wr_o),
    .pair_o   (cal_pair_o),
    .main_ok_o(main_ok),
    .aux_ok_o (aux_ok)
  );

  // registered reset pulses toward the converters
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      main_rst_q <= 1'b0;
      aux_rst_q  <= 1'b0;
    end else begin
      main_rst_q <= main_rst_req;
      aux_rst_q  <= aux_rst_req;
    end
  end
  assign main_rst_o = main_rst_q;
  assign aux_rst_o  = aux_rst_q;

endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
  parameter int RATE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic              main_rst_o,
  input logic              aux_rst_o,
  input logic              main_result_o,
  input logic              aux_result_o,
  input logic              cal_wr_o,
  input logic [RATE_W-1:0] rate_eff_o,
  input logic [2:0]        mode_q
);

  p_mode_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd0) |=> (main_rst_o && aux_rst_o));

  p_aux_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd3) |=> aux_rst_o);

  p_aux_wr_main_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd3) |=> !main_rst_o);

  p_stat_wr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd1) |=> (!main_rst_o && !aux_rst_o));

  p_aux_on_main_r6: assert property (@(posedge clk) disable iff (!rst_n)
    aux_result_o |-> main_result_o);

  p_aux_quiet_after_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    aux_rst_o |-> !aux_result_o);

  p_cal_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cal_wr_o |=> !cal_wr_o);

  p_cal_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cal_wr_o |-> (mode_q == 3'b001));

  p_cal_rate_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_wr_o |-> ($past(rate_eff_o) == '1));

endmodule

bind dualconv_seq dcs_checker #(.RATE_W(RATE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_we       (reg_we),
  .reg_addr     (reg_addr),
  .main_rst_o   (main_rst_o),
  .aux_rst_o    (aux_rst_o),
  .main_result_o(main_result_o),
  .aux_result_o (aux_result_o),
  .cal_wr_o     (cal_wr_o),
  .rate_eff_o   (rate_eff_o),
  .mode_q       (mode_q)
);

// File: tb/sim_dualconv_seq.sv
module sim_dualconv_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CALN       = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       main_rst_o, aux_rst_o, main_result_o, aux_result_o, cal_wr_o;
  logic [1:0] cal_pair_o;
  logic [7:0] rate_eff_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dualconv_seq u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .main_rst_o(main_rst_o),
    .aux_rst_o(aux_rst_o), .main_result_o(main_result_o),
    .aux_result_o(aux_result_o), .cal_wr_o(cal_wr_o),
    .cal_pair_o(cal_pair_o), .rate_eff_o(rate_eff_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  // called at a negedge; returns in the cycle after the write edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  function automatic bit exp_main_rst(input int a, input int d, input int shadow);
    return (a == 0) || (a == 2 && (shadow[7] || d[7]));
  endfunction

  function automatic bit exp_aux_rst(input int a, input int d, input int shadow);
    return exp_main_rst(a, d, shadow) || (a == 3);
  endfunction

  task automatic run_cal(input logic [2:0] m, input int pair, input int stat_done, input int rate);
    int v;
    int c0;
    wr(3'd0, {5'b0, m});
    c0 = cyc;
    rd(3'd1, v);
    chk("R8", "status after cal write", v, 32'h10);
    chk("R8", "rate_eff in cal", int'(rate_eff_o), 255);
    while (cyc - c0 < CALN) begin
      chk("R9", "no early store", int'(cal_wr_o), 0);
      step();
    end
    chk("R9", "store strobe", int'(cal_wr_o), 1);
    chk("R9", "pair", int'(cal_pair_o), pair);
    rd(3'd0, v);
    chk("R9", "mode back to idle", v, 1);
    rd(3'd1, v);
    chk("R9", "status done bit", v, stat_done);
    chk("R9", "rate restored", int'(rate_eff_o), rate);
    step();
    chk("R9", "strobe single", int'(cal_wr_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, base, n, c0, shadow, a, d;
    void'($urandom(32'd4242));
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    rd(3'd0, v); chk("R1", "mode", v, 1);
    rd(3'd1, v); chk("R1", "status", v, 0);
    rd(3'd2, v); chk("R1", "main ctrl", v, 7);
    rd(3'd3, v); chk("R1", "aux ctrl", v, 0);
    rd(3'd4, v); chk("R1", "rate", v, 5);
    chk("R1", "pulses", int'({main_rst_o, aux_rst_o, main_result_o, aux_result_o, cal_wr_o}), 0);

    // R2 same-value mode write
    wr(3'd0, 8'h01);
    chk("R2", "main rst", int'(main_rst_o), 1);
    chk("R2", "aux rst", int'(aux_rst_o), 1);
    step();
    chk("R2", "rst one cycle", int'(main_rst_o | aux_rst_o), 0);

    // R3 enable rules
    wr(3'd2, 8'h05);
    chk("R3", "disabled write no rst", int'(main_rst_o | aux_rst_o), 0);
    wr(3'd2, 8'h85);
    chk("R3", "enable rise rst", int'(main_rst_o & aux_rst_o), 1);
    wr(3'd2, 8'h05);
    chk("R3", "write while enabled rst", int'(main_rst_o & aux_rst_o), 1);
    wr(3'd2, 8'h05);
    chk("R3", "second disabled write", int'(main_rst_o | aux_rst_o), 0);

    // R12 status write ignored, unmapped reads
    wr(3'd1, 8'hFF);
    chk("R12", "status write rst", int'(main_rst_o | aux_rst_o), 0);
    rd(3'd1, v); chk("R12", "status unchanged", v, 0);
    for (int i = 5; i < 8; i++) begin
      rd(3'(i), v); chk("R12", "unmapped read", v, 0);
    end

    // R5 main cadence with R=3
    wr(3'd4, 8'd3);
    wr(3'd2, 8'h87);
    wr(3'd0, 8'h02);
    base = cyc;
    for (int i = 0; i < 13; i++) begin
      chk("R5", "main cadence", int'(main_result_o), ((cyc - base) % 4 == 3) ? 1 : 0);
      chk("R6", "aux idle", int'(aux_result_o), 0);
      step();
    end

    // R4 / R6 aux reset and alignment
    wr(3'd3, 8'h80);
    chk("R4", "aux rst", int'(aux_rst_o), 1);
    chk("R4", "main not reset", int'(main_rst_o), 0);
    n = 0;
    for (int i = 0; i < 22; i++) begin
      chk("R4", "main cadence kept", int'(main_result_o), ((cyc - base) % 4 == 3) ? 1 : 0);
      chk("R6", "aux alignment", int'(aux_result_o), (main_result_o && n >= 2) ? 1 : 0);
      if (main_result_o) n++;
      step();
    end

    // R7 ready bits
    rd(3'd1, v); chk("R7", "both ready", v & 3, 3);
    wr(3'd3, 8'h80);
    rd(3'd1, v); chk("R7", "aux ready cleared", v & 2, 0);
    wr(3'd2, 8'h07);
    rd(3'd1, v); chk("R7", "main ready cleared", v & 1, 0);
    for (int i = 0; i < 8; i++) begin
      chk("R7", "main stopped", int'(main_result_o), 0);
      step();
    end

    // R8 / R9 main zero-scale cal with a rate write during cal
    wr(3'd0, 8'h04);
    c0 = cyc;
    rd(3'd1, v); chk("R8", "status cleared busy set", v, 32'h10);
    chk("R8", "rate_eff max", int'(rate_eff_o), 255);
    rd(3'd4, v); chk("R8", "rate reg keeps user", v, 3);
    wr(3'd4, 8'd6);
    while (cyc - c0 < CALN) begin
      chk("R9", "no early store", int'(cal_wr_o), 0);
      chk("R8", "rate_eff held max", int'(rate_eff_o), 255);
      step();
    end
    chk("R9", "store strobe", int'(cal_wr_o), 1);
    chk("R9", "pair main zero", int'(cal_pair_o), 0);
    rd(3'd0, v); chk("R9", "mode idle", v, 1);
    rd(3'd1, v); chk("R9", "main done", v, 32'h04);
    chk("R9", "rate restored to last write", int'(rate_eff_o), 6);
    step();
    chk("R9", "strobe single", int'(cal_wr_o), 0);

    run_cal(3'b101, 1, 32'h04, 6);
    run_cal(3'b111, 3, 32'h08, 6);

    // R10 aux cal with temperature channel never completes
    wr(3'd3, 8'hF0);
    wr(3'd0, 8'h06);
    for (int i = 0; i < 3 * CALN; i++) begin
      chk("R10", "no store", int'(cal_wr_o), 0);
      step();
    end
    rd(3'd0, v); chk("R10", "mode kept", v, 6);
    rd(3'd1, v); chk("R10", "not busy", v & 32'h10, 0);
    chk("R10", "rate not forced", int'(rate_eff_o), 6);

    // R11 mode write on the completion edge
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h04);
    c0 = cyc;
    while (cyc - c0 < CALN - 1) step();
    wr(3'd0, 8'h02);
    chk("R11", "no store", int'(cal_wr_o), 0);
    rd(3'd0, v); chk("R11", "written mode wins", v, 2);
    rd(3'd1, v); chk("R11", "busy and done clear", v & 32'h14, 0);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R11", "no late store", int'(cal_wr_o), 0);
    end

    // random writes vs. reset rules (R2 R3 R4 R12)
    rd(3'd2, shadow);
    for (int i = 0; i < 300; i++) begin
      a = int'($urandom % 6);
      d = int'($urandom % 256);
      wr(3'(a), 8'(d));
      chk("R3", "random main rst", int'(main_rst_o), exp_main_rst(a, d, shadow) ? 1 : 0);
      chk("R4", "random aux rst", int'(aux_rst_o), exp_aux_rst(a, d, shadow) ? 1 : 0);
      if (a == 2) begin
        shadow = d;
        rd(3'd2, v); chk("R3", "main ctrl readback", v, shadow);
      end
    end

    ended = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule